// File: doc/BRIEF.md
# Carry-Pipelined Adder Summation Tree

This block adds a set of unsigned words that arrive together and produces their total. The words are combined pairwise in a binary tree of two-input adders. Every adder in the tree is cut into narrow slices, and each slice sits in its own pipeline register. The carry out of one slice is registered and consumed by the next slice one cycle later. The long carry chain of a full-width adder is therefore replaced by a short slice-wide chain. The clock period is set by one narrow adder and not by the word width.

To keep the slices in step, the input words are skewed: each higher slice is delayed by one more cycle than the slice below it. Inside the tree all values travel in this skewed form. At the root, the lower slices are delayed again so that every bit of the total appears in the same cycle. A new set of words can be presented on every clock. A valid flag travels beside the data with the same latency, which allows a stream with gaps to be followed at the output.

Top module: `pipe_sum_tree`

## Requirements
- R1: Counting the rising edge that samples the inputs as the first, the total appears on `out_sum` after the LAT-th rising edge, where LAT = ceil(log2 N_IN) + K_STG − 1 (5 with the defaults N_IN=5, K_STG=3, S_BITS=3). The total is the exact unsigned sum of all N_IN words.
- R2: `out_sum` is K_STG·S_BITS + ceil(log2 N_IN) bits wide (12 with the defaults). When every input word is all ones, the total is exact with no overflow, and `out_sum` never exceeds N_IN·(2^(K_STG·S_BITS) − 1).
- R3: A new input set is accepted on every clock, with no stall. Back-to-back sets give back-to-back totals in the same order.
- R4: `out_valid` repeats `in_valid` delayed by the same LAT edges as the data, for any pattern of gaps.
- R5: A synchronous reset empties the pipeline, including any data already in flight. On the first sample after a reset edge, `out_sum` is 0 and `out_valid` is 0.
- R6: A carry produced in any slice reaches all higher slices and the top bits. An example is 0x1FF + 0x001 = 0x200, which crosses every slice boundary.
- R7: Word i occupies bits [i·K_STG·S_BITS +: K_STG·S_BITS] of `in_words`. Each of the N_IN positions adds to the total on its own. When N_IN is not a power of two, the tree is filled out with zero operands.
- R8: `in_valid` does not gate the data path. Words presented while `in_valid` is low still produce their correct total on `out_sum`, with `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the current input set as meaningful |
| in_words | input | N_IN·K_STG·S_BITS | N_IN packed unsigned words, word i in the i-th field |
| out_valid | output | 1 | `in_valid` delayed by LAT cycles |
| out_sum | output | K_STG·S_BITS + ceil(log2 N_IN) | Aligned total of the input set sampled LAT edges earlier |

## Verification
The first patterns load a single word position at a time, so a wrong lane offset or a lost padding operand shows up as a wrong total. Next come pairs chosen so that a carry stops at one, two or all slice boundaries. These separate a broken carry register from a misaligned skew or deskew stage. All-ones inputs probe the widest total. Long random runs exercise the fully pipelined stream, first back to back and then with valid gaps and valid low. A reset in the middle of a stream shows that data already in flight is dropped.

// File: rtl/pipe_sum_tree.sv
module pipe_sum_tree #(
  parameter int N_IN   = 5,
  parameter int K_STG  = 3,
  parameter int S_BITS = 3,
  localparam int WORD_W = K_STG * S_BITS,
  localparam int LEV    = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int SUM_W  = WORD_W + LEV
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [N_IN*WORD_W-1:0] in_words,
  output logic                   out_valid,
  output logic [SUM_W-1:0]       out_sum
);
  localparam int NP  = 1 << LEV;
  localparam int LAT = LEV + K_STG - 1;
  localparam int TOP = (K_STG - 1) * S_BITS;

  wire [SUM_W-1:0] nd [LEV+1][NP];

  genvar i, j, l;

  for (i = 0; i < NP; i++) begin : g_in
    if (i < N_IN) begin : g_word
      for (j = 0; j < K_STG; j++) begin : g_slc
        if (j == 0) begin : g_now
          assign nd[0][i][S_BITS-1:0] = in_words[i*WORD_W +: S_BITS];
        end else begin : g_skew
          logic [S_BITS-1:0] ch [j];
          always_ff @(posedge clk) begin
            if (rst) begin
              for (int m = 0; m < j; m++) ch[m] <= '0;
            end else begin
              ch[0] <= in_words[i*WORD_W + j*S_BITS +: S_BITS];
              for (int m = 1; m < j; m++) ch[m] <= ch[m-1];
            end
          end
          assign nd[0][i][j*S_BITS +: S_BITS] = ch[j-1];
        end
      end
      assign nd[0][i][SUM_W-1:WORD_W] = '0;
    end else begin : g_pad
      assign nd[0][i] = '0;
    end
  end

  for (l = 1; l <= LEV; l++) begin : g_lvl
    for (i = 0; i < (NP >> l); i++) begin : g_add
      localparam int WI = WORD_W + l - 1;
      logic [WI:0]      q;
      logic [K_STG-1:0] cq;
      wire  [WI-1:0]    a = nd[l-1][2*i][WI-1:0];
      wire  [WI-1:0]    b = nd[l-1][2*i+1][WI-1:0];
      always_ff @(posedge clk) begin
        if (rst) begin
          q  <= '0;
          cq <= '0;
        end else begin
          cq[0] <= 1'b0;
          for (int m = 0; m < K_STG - 1; m++)
            {cq[m+1], q[m*S_BITS +: S_BITS]} <= {1'b0, a[m*S_BITS +: S_BITS]}
                                              + {1'b0, b[m*S_BITS +: S_BITS]}
                                              + {{S_BITS{1'b0}}, cq[m]};
          q[WI:TOP] <= {1'b0, a[WI-1:TOP]} + {1'b0, b[WI-1:TOP]}
                     + {{(WI-TOP){1'b0}}, cq[K_STG-1]};
        end
      end
      assign nd[l][i] = SUM_W'(q);
    end
  end

  wire [SUM_W-1:0] root = nd[LEV][0];

  for (j = 0; j < K_STG - 1; j++) begin : g_dsk
    localparam int D = K_STG - 1 - j;
    logic [S_BITS-1:0] dq [D];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int m = 0; m < D; m++) dq[m] <= '0;
      end else begin
        dq[0] <= root[j*S_BITS +: S_BITS];
        for (int m = 1; m < D; m++) dq[m] <= dq[m-1];
      end
    end
    assign out_sum[j*S_BITS +: S_BITS] = dq[D-1];
  end
  assign out_sum[SUM_W-1:TOP] = root[SUM_W-1:TOP];

  logic [LAT-1:0] vq;
  always_ff @(posedge clk) begin
    if (rst) vq <= '0;
    else     vq <= LAT'({vq, in_valid});
  end
  assign out_valid = vq[LAT-1];

  // Assertion support: independent history of input LSB parity and in-flight count
  localparam int CW = $clog2(LAT + 2);
  localparam logic [SUM_W:0] MAXS = (SUM_W+1)'(N_IN) * (SUM_W+1)'({WORD_W{1'b1}});
  logic           lsb_par;
  logic [LAT-1:0] par_h;
  logic [CW-1:0]  inflight;
  always_comb begin
    lsb_par = 1'b0;
    for (int m = 0; m < N_IN; m++) lsb_par = lsb_par ^ in_words[m*WORD_W];
  end
  always_ff @(posedge clk) begin
    if (rst) begin
      par_h    <= '0;
      inflight <= '0;
    end else begin
      par_h    <= LAT'({par_h, lsb_par});
      inflight <= inflight + CW'(in_valid) - CW'(out_valid);
    end
  end

  a_r5_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sum == '0));
  a_r1_lsb_parity: assert property (@(posedge clk) disable iff (rst)
    out_sum[0] == par_h[LAT-1]);
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    {1'b0, out_sum} <= MAXS);
  a_r4_valid_inflight: assert property (@(posedge clk) disable iff (rst)
    (out_valid |-> inflight != '0) and (inflight <= CW'(LAT)));
endmodule

// File: tb/pipe_sum_tree_tb.sv
module pipe_sum_tree_tb_top;
  localparam int N   = 5;
  localparam int K   = 3;
  localparam int S   = 3;
  localparam int W   = K * S;
  localparam int LV  = $clog2(N);
  localparam int SW  = W + LV;
  localparam int LAT = LV + K - 1;
  localparam time CLK_P = 20ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [N*W-1:0] in_words = '0;
  logic          out_valid;
  logic [SW-1:0] out_sum;

  int checks = 0;
  int errs   = 0;
  logic [SW-1:0] qs[$];
  logic          qv[$];
  string         qt[$];

  always #(CLK_P/2) clk = ~clk;

  pipe_sum_tree #(.N_IN(N), .K_STG(K), .S_BITS(S)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_words(in_words),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic check(input bit ok, input string tag, input logic [SW-1:0] act_s,
                       input logic act_v, input logic [SW-1:0] exp_s, input logic exp_v);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual sum=%0d valid=%0b expected sum=%0d valid=%0b",
               tag, act_s, act_v, exp_s, exp_v);
    end
  endtask

  task automatic step(input logic [N*W-1:0] w, input logic v, input logic r, input string tag);
    int s;
    logic [SW-1:0] es;
    logic ev;
    string et;
    @(negedge clk);
    if (qs.size() == LAT) begin
      es = qs.pop_front(); ev = qv.pop_front(); et = qt.pop_front();
      check(out_sum === es && out_valid === ev, et, out_sum, out_valid, es, ev);
    end
    rst = r; in_words = w; in_valid = v;
    if (r) begin
      qs.delete(); qv.delete(); qt.delete();
      for (int m = 0; m < LAT - 1; m++) begin
        qs.push_back('0); qv.push_back(1'b0); qt.push_back("R5");
      end
    end
    s = 0;
    for (int m = 0; m < N; m++) s += int'(w[m*W +: W]);
    qs.push_back(SW'(s)); qv.push_back(v); qt.push_back(tag);
  endtask

  function automatic logic [N*W-1:0] rnd_words();
    logic [N*W-1:0] w;
    for (int m = 0; m < N; m++) w[m*W +: W] = W'($urandom);
    return w;
  endfunction

  function automatic logic [N*W-1:0] pair(input int a, input int b);
    logic [N*W-1:0] w = '0;
    w[0 +: W] = W'(a);
    w[W +: W] = W'(b);
    return w;
  endfunction

  initial begin
    #(CLK_P * 200000);
    errs++; checks++;
    $display("FAIL R1: watchdog expired, actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [N*W-1:0] w;
    for (int c = 0; c < 3; c++) step('0, 1'b0, 1'b1, "R5");
    @(negedge clk);
    // R5: reset state seen at ports
    check(out_sum === '0 && out_valid === 1'b0, "R5", out_sum, out_valid, '0, 1'b0);
    // R2: output width
    check($bits(out_sum) == W + LV, "R2", SW'($bits(out_sum)), 1'b0, SW'(W + LV), 1'b0);
    step('0, 1'b0, 1'b0, "R5");
    // R7: each lane alone, including the padded tree
    for (int i = 0; i < N; i++) begin
      w = '0; w[i*W +: W] = W'(9'h1A5 - i * 37);
      step(w, 1'b1, 1'b0, "R7");
    end
    // R6: carries stopping at one, two and all slice boundaries
    step(pair(9'h007, 9'h001), 1'b1, 1'b0, "R6");
    step(pair(9'h03F, 9'h001), 1'b1, 1'b0, "R6");
    step(pair(9'h1FF, 9'h001), 1'b1, 1'b0, "R6");
    step(pair(9'h1FF, 9'h1FF), 1'b1, 1'b0, "R6");
    step(pair(9'h0C7, 9'h139), 1'b1, 1'b0, "R6");
    // R2: all ones
    step({N*W{1'b1}}, 1'b1, 1'b0, "R2");
    step({N*W{1'b1}}, 1'b0, 1'b0, "R2");
    // R3 / R1: back-to-back stream
    for (int c = 0; c < 40; c++) step(rnd_words(), 1'b1, 1'b0, "R3");
    // R8: valid low with live data
    for (int c = 0; c < 8; c++) step(rnd_words(), 1'b0, 1'b0, "R8");
    // R4 / R1: gappy valid
    for (int c = 0; c < 30; c++) step(rnd_words(), 1'($urandom), 1'b0, "R4");
    // R5: reset with data in flight
    step('0, 1'b0, 1'b1, "R5");
    for (int c = 0; c < 10; c++) step(rnd_words(), 1'b1, 1'b0, "R1");
    for (int c = 0; c < LAT + 1; c++) step('0, 1'b0, 1'b0, "R1");
    summary();
    $finish;
  end
endmodule